// File: doc/BRIEF.md
# Dual-Reference Level-Shifted H-Bridge Gate Generator

This block produces the switch gates for a chain of cascaded full-bridge cells. Every cell compares one triangular carrier with two modulation references at the same time. A shared up/down ramp creates all the carriers. They rise and fall together in phase, and each one sits on its own vertical step, so the carriers stack into non-overlapping bands. Four gate outcomes are possible for a cell, depending on where its carrier lies relative to the two references: a positive output, a negative output, or one of two zero states.

The mapping from cell to carrier band comes from an index field. The index is captured only at the bottom of the carrier ramp. A balancing controller can therefore reorder the bands once per carrier period, and the gate pattern never glitches inside a period. A one-clock strobe marks each ramp valley so that the controller can align its updates with it. With the default sizes and a 100 MHz clock, the carrier repeats every 50,000 cycles (2 kHz).

Top module: `lsd_hbridge_pwm`

## Requirements
- R1: While reset is high, and on the first clock edge after it is raised, every gate output is 0 and the strobe is 0.
- R2: The carrier of band L is L*TRI_PEAK plus a ramp. The ramp starts at 0 on the first tick after reset, climbs by one each tick up to TRI_PEAK, and then falls by one each tick. The period is 2*TRI_PEAK ticks, and one tick occurs every PRESC clocks.
- R3: When ref A is greater than the carrier and ref B is not greater than it, the cell's 4-bit gate field reads 4'b1001. Bit 0 is S1 and bit 3 is S4, so S1 and S4 are on.
- R4: When ref B is greater than the carrier and ref A is not greater than it, the gate field reads 4'b0110 (S2 and S3 on).
- R5: When neither reference is greater than the carrier, the gate field reads 4'b0011 (the upper-rail zero state, S1 and S2 on).
- R6: When both references are greater than the carrier, the gate field reads 4'b1100 (the lower-rail zero state, S3 and S4 on).
- R7: Outside reset, exactly two gates of a cell are on. S1 is never on together with S3, and S2 is never on together with S4.
- R8: A gate field reflects the references and the carrier sampled on the previous clock edge (one clock of latency).
- R9: The strobe is high for exactly one clock at each ramp valley, so it repeats every 2*TRI_PEAK*PRESC clocks.
- R10: Band indices are captured only on the edge that raises the strobe. An index change at any other time has no effect until the next valley.
- R11: An index greater than N_CELLS-1 selects the top band, N_CELLS-1.
- R12: The index of cell i sits in bits [3i+2:3i] of the selection input. The gate field of cell i sits in bits [4i+3:4i] of the gate output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_a_i | input | 16 | First modulation reference, signed |
| ref_b_i | input | 16 | Second modulation reference, signed |
| sel_i | input | 15 | Band index per cell, 3 bits each |
| gate_o | output | 20 | Gate fields, 4 bits per cell |
| strobe_o | output | 1 | One-clock pulse at each carrier valley |

## Verification
The properties assume that reset is high at the first clock edge. They also assume that the top band's carrier peak, N_CELLS*TRI_PEAK, fits in the signed reference width, so no carrier value wraps. They place no limit on the references or on the selection indices; out-of-range indices are legal input. The stimulus raises reset from time zero and changes inputs only on the falling clock edge. It keeps the band peak at 50 in a 16-bit signed range, and it uses indices both inside and above the band count. It also changes indices both before a valley and in the middle of a period.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;

  typedef enum logic [1:0] {
    BR_POS = 2'd0,
    BR_NEG = 2'd1,
    BR_ZHI = 2'd2,
    BR_ZLO = 2'd3
  } br_state_e;

  localparam int GATES_PER_CELL = 4;
  localparam logic [GATES_PER_CELL-1:0] GATE_OFF = 4'b0000;

  // bit0 = S1, bit1 = S2, bit2 = S3, bit3 = S4
  function automatic logic [GATES_PER_CELL-1:0] gate_of(br_state_e s);
    logic [GATES_PER_CELL-1:0] g;
    case (s)
      BR_POS:  g = 4'b1001;
      BR_NEG:  g = 4'b0110;
      BR_ZHI:  g = 4'b0011;
      default: g = 4'b1100;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/hbpwm_carrier.sv
module hbpwm_carrier #(
  parameter int DW       = 16,
  parameter int TRI_PEAK = 6250,
  parameter int PRESC    = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] ramp_o,
  output logic          wrap_o,
  output logic          strobe_o
);
  localparam int PERIOD = 2 * TRI_PEAK;
  localparam int PH_W   = $clog2(PERIOD);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0] PH_TOP  = PH_W'(TRI_PEAK);

  logic [PH_W-1:0] ph_q;
  logic            tick;

  generate
    if (PRESC <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRESC);
      localparam logic [PW-1:0] PC_LAST = PW'(PRESC - 1);
      logic [PW-1:0] pc_q;
      always_ff @(posedge clk) begin
        if (rst)                pc_q <= '0;
        else if (pc_q == PC_LAST) pc_q <= '0;
        else                    pc_q <= pc_q + 1'b1;
      end
      assign tick = (pc_q == PC_LAST);
    end
  endgenerate

  assign wrap_o = tick && (ph_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= wrap_o;
      if (tick) ph_q <= wrap_o ? '0 : ph_q + 1'b1;
    end
  end

  always_comb begin
    if (ph_q < PH_TOP) ramp_o = DW'(ph_q);
    else               ramp_o = DW'(PERIOD) - DW'(ph_q);
  end

endmodule

// File: rtl/hbpwm_selbank.sv
module hbpwm_selbank #(
  parameter int N_CELLS = 5,
  parameter int LW      = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [N_CELLS*LW-1:0] sel_i,
  output logic [N_CELLS*LW-1:0] lvl_o
);
  localparam logic [LW-1:0] TOP_LVL = LW'(N_CELLS - 1);

  for (genvar i = 0; i < N_CELLS; i++) begin : g_slot
    logic [LW-1:0] raw;
    logic [LW-1:0] lim;
    logic [LW-1:0] lv_q;

    assign raw = sel_i[i*LW +: LW];
    assign lim = (raw > TOP_LVL) ? TOP_LVL : raw;

    always_ff @(posedge clk) begin
      if (rst)       lv_q <= LW'(i);
      else if (load) lv_q <= lim;
    end

    assign lvl_o[i*LW +: LW] = lv_q;
  end

endmodule

// File: rtl/hbpwm_cell.sv
module hbpwm_cell
  import hbpwm_pkg::*;
#(
  parameter int DW       = 16,
  parameter int LW       = 3,
  parameter int TRI_PEAK = 6250
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] ref_a,
  input  logic signed [DW-1:0] ref_b,
  input  logic        [DW-1:0] ramp,
  input  logic        [LW-1:0] lvl,
  output logic [GATES_PER_CELL-1:0] gate_o
);
  localparam logic [DW-1:0] STEP = DW'(TRI_PEAK);

  logic signed [DW-1:0] car;
  logic                 a_hi;
  logic                 b_hi;
  br_state_e            st;

  assign car  = signed'(DW'(lvl) * STEP + ramp);
  assign a_hi = ref_a > car;
  assign b_hi = ref_b > car;

  always_comb begin
    case ({a_hi, b_hi})
      2'b10:   st = BR_POS;
      2'b01:   st = BR_NEG;
      2'b11:   st = BR_ZLO;
      default: st = BR_ZHI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) gate_o <= GATE_OFF;
    else     gate_o <= gate_of(st);
  end

endmodule

// File: rtl/lsd_hbridge_pwm.sv
module lsd_hbridge_pwm #(
  parameter int N_CELLS  = 5,
  parameter int DW       = 16,
  parameter int TRI_PEAK = 6250,
  parameter int PRESC    = 4
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic signed [DW-1:0]                  ref_a_i,
  input  logic signed [DW-1:0]                  ref_b_i,
  input  logic [N_CELLS*$clog2(N_CELLS)-1:0]    sel_i,
  output logic [N_CELLS*4-1:0]                  gate_o,
  output logic                                  strobe_o
);
  localparam int LW = $clog2(N_CELLS);
  localparam int GW = hbpwm_pkg::GATES_PER_CELL;

  logic [DW-1:0]         ramp_w;
  logic                  wrap_w;
  logic [N_CELLS*LW-1:0] lvl_w;

  hbpwm_carrier #(
    .DW(DW), .TRI_PEAK(TRI_PEAK), .PRESC(PRESC)
  ) u_carrier (
    .clk(clk), .rst(rst), .ramp_o(ramp_w), .wrap_o(wrap_w), .strobe_o(strobe_o)
  );

  hbpwm_selbank #(
    .N_CELLS(N_CELLS), .LW(LW)
  ) u_selbank (
    .clk(clk), .rst(rst), .load(wrap_w), .sel_i(sel_i), .lvl_o(lvl_w)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    hbpwm_cell #(
      .DW(DW), .LW(LW), .TRI_PEAK(TRI_PEAK)
    ) u_cell (
      .clk(clk), .rst(rst),
      .ref_a(ref_a_i), .ref_b(ref_b_i),
      .ramp(ramp_w), .lvl(lvl_w[i*LW +: LW]),
      .gate_o(gate_o[i*GW +: GW])
    );
  end

endmodule

// File: rtl/lsd_hbridge_pwm_chk.sv
module lsd_hbridge_pwm_chk #(
  parameter int N_CELLS = 5,
  parameter int LW      = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic [N_CELLS*4-1:0]  gate,
  input logic                  strobe,
  input logic [N_CELLS*LW-1:0] lvl
);
  localparam logic [LW-1:0] TOP_LVL = LW'(N_CELLS - 1);

  for (genvar i = 0; i < N_CELLS; i++) begin : g_c
    AST_LEGS_APART: assert property (@(posedge clk) disable iff (rst)
      !(gate[4*i] && gate[4*i+2]) && !(gate[4*i+1] && gate[4*i+3])); // R7
    AST_TWO_ON: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ($countones(gate[4*i +: 4]) == 2)); // R7
    AST_LVL_RANGE: assert property (@(posedge clk) disable iff (rst)
      lvl[i*LW +: LW] <= TOP_LVL); // R11
  end

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe); // R9
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe |-> $stable(lvl)); // R10

endmodule

bind lsd_hbridge_pwm lsd_hbridge_pwm_chk #(.N_CELLS(N_CELLS), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .gate(gate_o), .strobe(strobe_o), .lvl(lvl_w)
);

// File: tb/lsd_hbridge_pwm_tb_top.sv
module lsd_hbridge_pwm_tb_top;
  localparam int N     = 5;
  localparam int DW    = 16;
  localparam int PEAK  = 10;
  localparam int PRESC = 1;
  localparam int LW    = 3;
  localparam int NV    = 8;

  localparam logic [14:0] S_ID   = 15'b100_011_010_001_000;
  localparam logic [14:0] S_ALL2 = 15'b010_010_010_010_010;
  localparam logic [14:0] S_ALL7 = 15'b111_111_111_111_111;
  localparam logic [14:0] S_REV  = 15'b000_001_010_011_100;
  localparam logic [14:0] S_ALL4 = 15'b100_100_100_100_100;

  localparam int          VA[NV] = '{100, -100, 25, 15, 27, 45, 22, 0};
  localparam int          VB[NV] = '{-100, 100, 15, 35, 0, -1, 12, 0};
  localparam int          VP[NV] = '{3, 3, 6, 11, 15, 4, 19, 2};
  localparam logic [14:0] VS[NV] = '{S_ID, S_ID, S_ID, S_ID, S_ALL2, S_ALL7, S_REV, S_ID};

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic signed [DW-1:0] ra = '0;
  logic signed [DW-1:0] rb = '0;
  logic [14:0]          sel = S_ID;
  logic [N*4-1:0]       gate;
  logic                 strobe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lsd_hbridge_pwm #(.N_CELLS(N), .DW(DW), .TRI_PEAK(PEAK), .PRESC(PRESC)) dut_i (
    .clk(clk), .rst(rst), .ref_a_i(ra), .ref_b_i(rb), .sel_i(sel),
    .gate_o(gate), .strobe_o(strobe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ramp_at(int q);
    return (q < PEAK) ? q : 2 * PEAK - q;
  endfunction

  function automatic logic [3:0] exp_gate(int a, int b, int c);
    bit ah = a > c;
    bit bh = b > c;
    if (ah && !bh) return 4'b1001;  // R3
    if (!ah && bh) return 4'b0110;  // R4
    if (ah && bh)  return 4'b1100;  // R6
    return 4'b0011;                 // R5
  endfunction

  function automatic string tag_of(logic [3:0] g);
    case (g)
      4'b1001: return "R3";
      4'b0110: return "R4";
      4'b0011: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic wait_valley();
    do @(negedge clk); while (strobe !== 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 gates in reset", int'(gate), 0);
    chk("R1 strobe in reset", int'(strobe), 0);
    rst = 1'b0;

    // vector table walk, R12 field positions via per-cell slices
    for (int v = 0; v < NV; v++) begin
      ra  = 16'(VA[v]);
      rb  = 16'(VB[v]);
      sel = VS[v];
      wait_valley();
      repeat (VP[v]) @(negedge clk);
      for (int c = 0; c < N; c++) begin
        int lv;
        logic [3:0] e;
        string t;
        lv = int'(VS[v][3*c +: 3]);
        if (lv > N - 1) lv = N - 1;
        e = exp_gate(VA[v], VB[v], lv * PEAK + ramp_at(VP[v] - 1));
        t = tag_of(e);
        if (v == 5) t = {t, " R11"};
        if (v == 6) t = {t, " R12"};
        chk(t, int'(gate[4*c +: 4]), int'(e));
      end
    end

    // R9 strobe spacing and width
    begin
      int cnt;
      wait_valley();
      @(negedge clk);
      chk("R9 strobe width", int'(strobe), 0);
      cnt = 1;
      while (strobe !== 1'b1) begin
        @(negedge clk);
        cnt++;
      end
      chk("R9 strobe period", cnt, 2 * PEAK * PRESC);
    end

    // R2 carrier shape: cell0 band 0 against ref B = 5
    begin
      int hits;
      ra = 16'sd100; rb = 16'sd5; sel = S_ID;
      wait_valley();
      wait_valley();
      hits = 0;
      for (int k = 0; k < 2 * PEAK; k++) begin
        @(negedge clk);
        if (gate[3:0] == 4'b1001) hits++;
      end
      chk("R2 ramp cycles at or above 5", hits, 11);
    end

    // R10 mid-period index change deferred
    ra = 16'sd15; rb = -16'sd100; sel = S_ID;
    wait_valley();
    repeat (2) @(negedge clk);
    sel = S_ALL4;
    repeat (3) @(negedge clk);
    chk("R10 old band kept", int'(gate[3:0]), int'(4'b1001));
    wait_valley();
    repeat (5) @(negedge clk);
    chk("R10 new band at valley", int'(gate[3:0]), int'(4'b0011));

    // R8 one clock latency
    sel = S_ID; ra = 16'sd100; rb = -16'sd100;
    wait_valley();
    repeat (3) @(negedge clk);
    chk("R8 before change", int'(gate[11:8]), int'(4'b1001));
    ra = -16'sd100; rb = 16'sd100;
    chk("R8 no same-cycle effect", int'(gate[11:8]), int'(4'b1001));
    @(negedge clk);
    chk("R8 one clock later", int'(gate[11:8]), int'(4'b0110));

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R1 gates after reset", int'(gate), 0);
    chk("R1 strobe after reset", int'(strobe), 0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule